// File: doc/BRIEF.md
# PHY Test-Port Register Write Sequencer

This block carries out one register write into a D-PHY over its serial test port. A one-cycle start request comes with an 8-bit register code and an 8-bit value. The engine then drives the port's clear, strobe, enable and data-in pins through a fixed eight-step pattern.

First, a clear pulse resets the port. Next, the strobe rises while enable is low. The code is then presented with enable high, and the strobe's falling edge makes the PHY latch it. Enable then drops and the value is presented, and the strobe's rising edge makes the PHY latch the value. Finally the strobe returns low. A typical use is programming the PHY's high-speed frequency-range selection, which lives at register code 0x44.

Every step is held for `HOLD_CYCLES` system clocks, so the slow test port sees clean and well separated edges. A `busy_o` level covers the whole write, and `done_o` pulses in its final cycle.

Top module: `phy_tif_writer`

## Requirements
- R1: During and directly after a synchronous active-low reset, `tst_clr_o`, `tst_clk_o`, `tst_en_o`, `tst_din_o`, `busy_o` and `done_o` are all 0. A reset in the middle of a write returns the block to this idle state.
- R2: An accepted write begins with a step where `tst_clr_o`=1 while strobe, enable and data-in are all 0. The next step has all four pins at 0.
- R3: In step 3 the strobe rises with enable 0 and data-in 0.
- R4: In step 4 enable goes to 1 and the latched code is placed on data-in while the strobe stays 1. In step 5 the strobe falls while enable stays 1 and the code stays on data-in. Each write produces exactly one falling strobe edge with enable high, and the data-in value at that edge equals the code.
- R5: In step 6 enable returns to 0 and the latched value is placed on data-in while the strobe stays 0. In step 7 the strobe rises and the value stays on data-in. The last rising strobe edge with enable low carries the value.
- R6: In step 8 the strobe returns to 0 and the value stays on data-in. `done_o` is 1 only in the final cycle of step 8. In the following cycle all pins are 0.
- R7: Each of the eight steps lasts exactly `HOLD_CYCLES` clocks. The first step starts in the cycle after the clock edge that accepted the start, so a write lasts 8*`HOLD_CYCLES` cycles.
- R8: A start request that arrives while `busy_o` is 1, including in the `done_o` cycle, is ignored. The running write keeps its code, value and timing, and no second write follows.
- R9: `busy_o` is 1 from the cycle after an accepted start through the `done_o` cycle, and 0 otherwise.
- R10: The code and value are sampled only at the accepting edge. Later changes on `code_i` and `data_i` do not reach the pins during that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one write; honoured only when idle |
| code_i | input | 8 | PHY register code to write |
| data_i | input | 8 | Value to write |
| busy_o | output | 1 | A write is in progress |
| done_o | output | 1 | One-cycle pulse in the final cycle of a write |
| tst_clr_o | output | 1 | Test-port clear |
| tst_clk_o | output | 1 | Test-port strobe |
| tst_en_o | output | 1 | Test-port enable (high while the code is presented) |
| tst_din_o | output | 8 | Test-port data-in |

## Verification
The hardest situations to reach are the ones where stimulus lands mid-write. One is a second start, with new operands, arriving in the middle of a step or exactly in the `done_o` cycle. The other is a reset arriving while the value is on the pins. The directed tasks place these events at chosen cycle offsets from the accepted start. Every cycle of the write is compared against a per-step expectation. A small model of the PHY, driven by the strobe edges, confirms which code and value a real PHY would have latched.

// File: rtl/phy_tif_pkg.sv
package phy_tif_pkg;

  localparam int unsigned NUM_STEPS = 8;

  typedef enum logic [3:0] {
    ST_IDLE       = 4'd0,
    ST_CLR_SET    = 4'd1,
    ST_CLR_REL    = 4'd2,
    ST_CLK_UP     = 4'd3,
    ST_ADDR       = 4'd4,
    ST_ADDR_LATCH = 4'd5,
    ST_DATA       = 4'd6,
    ST_DATA_LATCH = 4'd7,
    ST_FINISH     = 4'd8
  } step_t;

  typedef struct packed {
    logic clr;
    logic stb;
    logic en;
    logic put_code;
    logic put_data;
  } pin_plan_t;

  function automatic step_t step_after(step_t s);
    case (s)
      ST_CLR_SET:    return ST_CLR_REL;
      ST_CLR_REL:    return ST_CLK_UP;
      ST_CLK_UP:     return ST_ADDR;
      ST_ADDR:       return ST_ADDR_LATCH;
      ST_ADDR_LATCH: return ST_DATA;
      ST_DATA:       return ST_DATA_LATCH;
      ST_DATA_LATCH: return ST_FINISH;
      default:       return ST_IDLE;
    endcase
  endfunction

  function automatic pin_plan_t plan_of(step_t s);
    pin_plan_t p;
    p = '0;
    case (s)
      ST_CLR_SET:    p.clr = 1'b1;
      ST_CLK_UP:     p.stb = 1'b1;
      ST_ADDR:       begin p.stb = 1'b1; p.en = 1'b1; p.put_code = 1'b1; end
      ST_ADDR_LATCH: begin p.en = 1'b1; p.put_code = 1'b1; end
      ST_DATA:       p.put_data = 1'b1;
      ST_DATA_LATCH: begin p.stb = 1'b1; p.put_data = 1'b1; end
      ST_FINISH:     p.put_data = 1'b1;
      default:       p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/phy_tif_hold_timer.sv
module phy_tif_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);

  generate
    if (HOLD_CYCLES <= 1) begin : g_single
      assign last_o = run_i;
    end else begin : g_count
      localparam int unsigned CW = $clog2(HOLD_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!run_i)           cnt_q <= '0;
        else if (cnt_q == LAST)    cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
      end

      assign last_o = run_i && (cnt_q == LAST);

      // R7: counter never leaves its window
      a_r7_cnt_window: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
      // R7: an idle timer restarts from zero
      a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
    end
  endgenerate

endmodule

// File: rtl/phy_tif_seq.sv
module phy_tif_seq
  import phy_tif_pkg::*;
#(
  parameter int unsigned DIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIN_W-1:0] code_i,
  input  logic [DIN_W-1:0] data_i,
  input  logic             adv_i,
  output step_t            step_o,
  output step_t            step_nxt_o,
  output logic [DIN_W-1:0] code_o,
  output logic [DIN_W-1:0] data_o,
  output logic             busy_o,
  output logic             accept_o
);

  step_t            step_q;
  logic [DIN_W-1:0] code_q;
  logic [DIN_W-1:0] data_q;

  assign busy_o   = (step_q != ST_IDLE);
  assign accept_o = !busy_o && start_i;

  always_comb begin
    if (!busy_o)     step_nxt_o = accept_o ? ST_CLR_SET : ST_IDLE;
    else if (adv_i)  step_nxt_o = step_after(step_q);
    else             step_nxt_o = step_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      code_q <= '0;
      data_q <= '0;
    end else begin
      step_q <= step_nxt_o;
      if (accept_o) begin
        code_q <= code_i;
        data_q <= data_i;
      end
    end
  end

  assign step_o = step_q;
  assign code_o = code_q;
  assign data_o = data_q;

  // R8, R10: operands frozen while a write runs
  a_r8_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(code_q) && $stable(data_q));
  // R7: a step only moves on when the hold timer says so
  a_r7_step_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !adv_i) |=> step_q == $past(step_q));
  // R9: an accepted start always opens with the clear step
  a_r9_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> step_q == ST_CLR_SET);

endmodule

// File: rtl/phy_tif_drive.sv
module phy_tif_drive
  import phy_tif_pkg::*;
#(
  parameter int unsigned DIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_t            step_nxt_i,
  input  logic [DIN_W-1:0] code_nxt_i,
  input  logic [DIN_W-1:0] data_nxt_i,
  output logic             tst_clr_o,
  output logic             tst_clk_o,
  output logic             tst_en_o,
  output logic [DIN_W-1:0] tst_din_o
);

  pin_plan_t        plan;
  logic [DIN_W-1:0] din_nxt;

  assign plan = plan_of(step_nxt_i);

  always_comb begin
    if (plan.put_code)      din_nxt = code_nxt_i;
    else if (plan.put_data) din_nxt = data_nxt_i;
    else                    din_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tst_clr_o <= 1'b0;
      tst_clk_o <= 1'b0;
      tst_en_o  <= 1'b0;
      tst_din_o <= '0;
    end else begin
      tst_clr_o <= plan.clr;
      tst_clk_o <= plan.stb;
      tst_en_o  <= plan.en;
      tst_din_o <= din_nxt;
    end
  end

  // R2: clear is asserted alone
  a_r2_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
    tst_clr_o |-> !tst_clk_o && !tst_en_o && (tst_din_o == '0));
  // R3, R4: enable only rises while the strobe is already high
  a_r4_en_rise_under_stb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tst_en_o) |-> tst_clk_o && $past(tst_clk_o));
  // R4: code steady across the capturing falling edge
  a_r4_code_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tst_clk_o) && tst_en_o) |-> $stable(tst_din_o) && $past(tst_en_o));
  // R5: data steady across the capturing rising edge
  a_r5_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tst_clk_o) && !tst_en_o) |-> $stable(tst_din_o) && !$past(tst_en_o));

endmodule

// File: rtl/phy_tif_writer.sv
module phy_tif_writer
  import phy_tif_pkg::*;
#(
  parameter int unsigned DIN_W       = 8,
  parameter int unsigned HOLD_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIN_W-1:0] code_i,
  input  logic [DIN_W-1:0] data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             tst_clr_o,
  output logic             tst_clk_o,
  output logic             tst_en_o,
  output logic [DIN_W-1:0] tst_din_o
);

  localparam int unsigned WRITE_CYCLES = NUM_STEPS * HOLD_CYCLES;

  step_t            step_cur;
  step_t            step_nxt;
  logic [DIN_W-1:0] code_held;
  logic [DIN_W-1:0] data_held;
  logic             step_last;
  logic             accepted;
  logic             finishing;

  phy_tif_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy_o),
    .last_o (step_last)
  );

  phy_tif_seq #(.DIN_W(DIN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .code_i     (code_i),
    .data_i     (data_i),
    .adv_i      (step_last),
    .step_o     (step_cur),
    .step_nxt_o (step_nxt),
    .code_o     (code_held),
    .data_o     (data_held),
    .busy_o     (busy_o),
    .accept_o   (accepted)
  );

  // Pins are registered from the next step and the next operands,
  // so the pin flops line up with step_cur.
  logic [DIN_W-1:0] code_nxt;
  logic [DIN_W-1:0] data_nxt;
  assign code_nxt = accepted ? code_i : code_held;
  assign data_nxt = accepted ? data_i : data_held;

  phy_tif_drive #(.DIN_W(DIN_W)) u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_nxt_i (step_nxt),
    .code_nxt_i (code_nxt),
    .data_nxt_i (data_nxt),
    .tst_clr_o  (tst_clr_o),
    .tst_clk_o  (tst_clk_o),
    .tst_en_o   (tst_en_o),
    .tst_din_o  (tst_din_o)
  );

  assign finishing = (step_cur == ST_FINISH) && step_last;
  assign done_o    = finishing;

  // R6: done is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R6: after done every pin is low
  a_r6_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o && !tst_clk_o && !tst_en_o && !tst_clr_o && (tst_din_o == '0));
  // R9: done falls inside the busy window
  a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);
  // R8: a start during busy does not extend the write
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && done_o) |=> !busy_o);
  // R1: idle means quiet pins
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !tst_clk_o && !tst_en_o && !tst_clr_o);
  // R7: write length is a whole number of steps
  initial a_r7_length_sane: assert (WRITE_CYCLES >= NUM_STEPS);

endmodule

// File: tb/phy_tif_writer_test.sv
module phy_tif_writer_test;

  localparam int HOLD = 3;
  localparam int LEN  = 8 * HOLD;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] code_i = '0;
  logic [7:0] data_i = '0;
  logic       busy_o, done_o, tst_clr_o, tst_clk_o, tst_en_o;
  logic [7:0] tst_din_o;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  // PHY-side capture model
  int         fall_en_cnt = 0;
  int         rise_noen_cnt = 0;
  logic [7:0] cap_code = '0;
  logic [7:0] cap_data = '0;

  always #4 clk = ~clk;

  phy_tif_writer #(.DIN_W(8), .HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .code_i(code_i), .data_i(data_i),
    .busy_o(busy_o), .done_o(done_o), .tst_clr_o(tst_clr_o), .tst_clk_o(tst_clk_o),
    .tst_en_o(tst_en_o), .tst_din_o(tst_din_o)
  );

  always @(negedge tst_clk_o) if (rst_n && tst_en_o === 1'b1) begin
    fall_en_cnt++; cap_code = tst_din_o;
  end
  always @(posedge tst_clk_o) if (rst_n && tst_en_o === 1'b0) begin
    rise_noen_cnt++; cap_data = tst_din_o;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "clr", tst_clr_o, 0);
    chk(req, "stb", tst_clk_o, 0);
    chk(req, "en", tst_en_o, 0);
    chk(req, "din", tst_din_o, 0);
    chk(req, "busy", busy_o, 0);
    chk(req, "done", done_o, 0);
  endtask

  // Per-phase expectation: bit p of each mask is phase p (0..7).
  task automatic chk_phase(input int t, input logic [7:0] c, input logic [7:0] d);
    int p = t / HOLD;
    logic [7:0] clr_m = 8'b0000_0001;
    logic [7:0] stb_m = 8'b0100_1100;
    logic [7:0] en_m  = 8'b0001_1000;
    int din_e;
    string rq;
    if (p == 3 || p == 4) din_e = c;
    else if (p >= 5)      din_e = d;
    else                  din_e = 0;
    case (p)
      0, 1:    rq = "R2/R7";
      2:       rq = "R3/R7";
      3, 4:    rq = "R4/R7";
      5, 6:    rq = "R5/R7";
      default: rq = "R6/R7";
    endcase
    chk(rq, $sformatf("clr t=%0d", t), tst_clr_o, clr_m[p]);
    chk(rq, $sformatf("stb t=%0d", t), tst_clk_o, stb_m[p]);
    chk(rq, $sformatf("en t=%0d", t), tst_en_o, en_m[p]);
    chk(rq, $sformatf("din t=%0d", t), tst_din_o, din_e);
    chk("R9", $sformatf("busy t=%0d", t), busy_o, 1);
    chk("R6", $sformatf("done t=%0d", t), done_o, (t == LEN - 1) ? 1 : 0);
  endtask

  // One full write. poke_t >= 0 raises start with new operands at that offset (R8, R10).
  task automatic run_write(input logic [7:0] c, input logic [7:0] d, input int poke_t,
                           input logic [7:0] pc, input logic [7:0] pd, input bit start_at_done);
    int f0 = fall_en_cnt;
    int r0 = rise_noen_cnt;
    @(negedge clk); code_i = c; data_i = d; start_i = 1'b1;
    @(negedge clk);
    for (int t = 0; t <= LEN + 1; t++) begin
      if (t < LEN) chk_phase(t, c, d);
      else         chk_idle("R6/R8");
      if (t == poke_t) begin start_i = 1'b1; code_i = pc; data_i = pd; end
      else if (start_at_done && t == LEN - 1) start_i = 1'b1;
      else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R4", "captured code", cap_code, c);
    chk("R4", "falling edges with en", fall_en_cnt - f0, 1);
    chk("R5", "captured data", cap_data, d);
    chk("R5", "rising edges without en", rise_noen_cnt - r0, 2);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");
  endtask

  task automatic t_plain;
    run_write(8'h44, 8'h2c, -1, 8'h00, 8'h00, 1'b0);  // frequency-range code
    run_write(8'hA5, 8'h5A, -1, 8'h00, 8'h00, 1'b0);
    run_write(8'hFF, 8'h00, -1, 8'h00, 8'h00, 1'b0);
    run_write(8'h00, 8'hFF, -1, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_ignore_start;
    // R8 / R10: second start with new operands mid-write, inside a hold window
    run_write(8'h12, 8'h34, 2 * HOLD + 1, 8'hEE, 8'hDD, 1'b0);
    run_write(8'h56, 8'h78, 5 * HOLD, 8'h99, 8'h88, 1'b0);
    // R8: start exactly in the done cycle is dropped
    run_write(8'h3C, 8'hC3, -1, 8'h00, 8'h00, 1'b1);
  endtask

  task automatic t_reset_mid;
    @(negedge clk); code_i = 8'h77; data_i = 8'h66; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (5 * HOLD + 1) @(negedge clk);
    chk("R1", "busy before reset", busy_o, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_idle("R1");
    run_write(8'h81, 8'h18, -1, 8'h00, 8'h00, 1'b0);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_ignore_start();
    t_reset_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule